// File: doc/BRIEF.md
# Low-Frequency Reader Command Frame Serializer

This block turns one reader-to-transponder command into a serial bit stream for a low-frequency tag link. A command is requested with a 3-bit opcode and a start strobe. The block captures the opcode and the payload inputs it needs in that same cycle. The payload inputs are the random challenge, the authenticator, the block address, the 16-bit write word, the tag identity and the PIN. The block then waits for the tag to open a listen window, which is signalled by a one-cycle sync strobe. After the sync it sends one bit per external bit-slot tick, most significant bit first.

Every frame opens with a six-bit prefix: two zero bits, the opcode, and one parity bit that makes the number of ones in the prefix even. The command-specific payload follows the prefix.
- The three read commands have no payload.
- Authentication carries the challenge, a zero-filled divider field and the authenticator.
- A block write carries the address, an even parity bit for the address, and a 5x5 even-parity grid that the block builds from the 16-bit word.
- PIN delivery carries the identity and then the PIN.

Modulation, bit timing and the computation of the cryptographic values are done outside this block.

Top module: `lftx_frame_ser`

## Requirements
- R1: After reset `busy_o`, `txv_o`, `done_o` and `txd_o` are all 0.
- R2: A start with a known opcode while idle sets `busy_o` in the next cycle. No bit is sent before a later `sync_i` pulse, and `tick_i` pulses before that sync produce no `txv_o`.
- R3: After the sync, each `tick_i` seen in a later cycle produces exactly one `txv_o` pulse in the following cycle, with the bit on `txd_o`. `txv_o` is never high without a tick in the cycle before.
- R4: The first six bits are 0, 0, the opcode MSB first, and then a parity bit equal to the XOR of the opcode bits. Opcodes: ID read 001, first user area read 010, second user area read 111, authenticate 011, block write 101, PIN delivery 100.
- R5: The read opcodes 001, 010 and 111 send only the 6-bit prefix.
- R6: Authenticate (011) sends the 56-bit challenge, then 7 zero bits, then the 28-bit authenticator, each MSB first, for 97 bits in total.
- R7: Block write (101) sends the 4-bit address MSB first, then the XOR of the address bits, then 25 grid bits, for 36 bits in total.
- R8: The grid is sent row by row. Rows 0 to 3 each hold one nibble of the write word, taken from bits 15:12 down to 3:0 and sent MSB first, followed by the XOR of that nibble. The last row holds the XOR of each column (leftmost column first), followed by the XOR of all 16 word bits.
- R9: PIN delivery (100) sends the 32-bit identity and then the 32-bit PIN, both MSB first, for 70 bits in total.
- R10: `done_o` is a one-cycle pulse in the same cycle as the final `txv_o`, and `busy_o` is 0 in that cycle.
- R11: A start while busy is ignored. The frame in progress, including the payload captured when it was accepted, is sent unchanged.
- R12: A start with opcode 000 or 110 is ignored, and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send a frame |
| cmd_i | input | 3 | Opcode of the requested frame |
| sync_i | input | 1 | Listen-window sync strobe from the tag |
| tick_i | input | 1 | Bit-slot tick |
| rn_i | input | 56 | Authentication challenge |
| auth_i | input | 28 | Authenticator value |
| addr_i | input | 4 | Block address for a write |
| wword_i | input | 16 | Write data before grid encoding |
| tagid_i | input | 32 | Tag identity for PIN delivery |
| pin_i | input | 32 | PIN value |
| txd_o | output | 1 | Serial bit, valid while `txv_o` is high |
| txv_o | output | 1 | One-cycle strobe marking a new bit |
| busy_o | output | 1 | A frame is armed or being sent |
| done_o | output | 1 | The final bit of a frame is being presented |

## Verification
The assertions check the cycle-level handshakes on every cycle. Each bit strobe must follow a tick, `done_o` must come with a bit strobe while `busy_o` is low, an idle block must emit nothing, and rejected opcodes must not raise `busy_o`. Only the bench scenarios can show the frame contents and lengths: the prefix parity, the zero divider, the address parity and the parity grid. The bench also shows that ticks before the sync are ignored and that a frame disturbed by new starts keeps its captured payload.

// File: rtl/lftx_pkg.sv
package lftx_pkg;

    localparam int PREFIX_W = 6;

    typedef enum logic [2:0] {
        OP_ID   = 3'b001,
        OP_UM1  = 3'b010,
        OP_AUTH = 3'b011,
        OP_PIN  = 3'b100,
        OP_WR   = 3'b101,
        OP_UM2  = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_SEND  = 2'd2
    } st_e;

    function automatic logic op_known(input logic [2:0] c);
        logic k;
        case (c)
            OP_ID, OP_UM1, OP_AUTH, OP_PIN, OP_WR, OP_UM2: k = 1'b1;
            default:                                       k = 1'b0;
        endcase
        return k;
    endfunction

    function automatic logic [PREFIX_W-1:0] prefix_of(input logic [2:0] c);
        return {2'b00, c, ^c};
    endfunction

endpackage

// File: rtl/lftx_grid_enc.sv
module lftx_grid_enc #(
    parameter  int ROWS = 4,
    parameter  int COLS = 4,
    localparam int DW   = ROWS * COLS,
    localparam int GW   = (ROWS + 1) * (COLS + 1)
) (
    input  logic [DW-1:0] word_i,
    output logic [GW-1:0] grid_o
);

    // Cell (r,c) of the grid sits at bit GW-1-(r*(COLS+1)+c), row-major, MSB first.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_cell
            assign grid_o[GW-1-(r*(COLS+1)+c)] = word_i[DW-1-(r*COLS+c)];
        end
        assign grid_o[GW-1-(r*(COLS+1)+COLS)] = ^word_i[DW-1-r*COLS -: COLS];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] colbits;
        for (genvar r = 0; r < ROWS; r++) begin : g_pick
            assign colbits[r] = word_i[DW-1-(r*COLS+c)];
        end
        assign grid_o[GW-1-(ROWS*(COLS+1)+c)] = ^colbits;
    end

    assign grid_o[0] = ^word_i;

endmodule

// File: rtl/lftx_frame_build.sv
module lftx_frame_build
    import lftx_pkg::*;
#(
    parameter int RN_W    = 56,
    parameter int DIV_W   = 7,
    parameter int AUTH_W  = 28,
    parameter int ADDR_W  = 4,
    parameter int ROWS    = 4,
    parameter int COLS    = 4,
    parameter int ID_W    = 32,
    parameter int PIN_W   = 32,
    parameter int FRAME_W = 97,
    parameter int CNT_W   = 7
) (
    input  logic [2:0]         cmd_i,
    input  logic [RN_W-1:0]    rn_i,
    input  logic [AUTH_W-1:0]  auth_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [ROWS*COLS-1:0] wword_i,
    input  logic [ID_W-1:0]    tagid_i,
    input  logic [PIN_W-1:0]   pin_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o,
    output logic               known_o
);

    localparam int GW       = (ROWS + 1) * (COLS + 1);
    localparam int TOP      = FRAME_W - 1 - PREFIX_W;
    localparam int AUTH_LEN = PREFIX_W + RN_W + DIV_W + AUTH_W;
    localparam int WR_LEN   = PREFIX_W + ADDR_W + 1 + GW;
    localparam int PIN_LEN  = PREFIX_W + ID_W + PIN_W;

    logic [GW-1:0] grid;

    lftx_grid_enc #(.ROWS(ROWS), .COLS(COLS)) u_grid (
        .word_i (wword_i),
        .grid_o (grid)
    );

    always_comb begin
        frame_o                        = '0;
        frame_o[FRAME_W-1 -: PREFIX_W] = prefix_of(cmd_i);
        len_o                          = CNT_W'(PREFIX_W);
        known_o                        = op_known(cmd_i);
        case (cmd_i)
            OP_AUTH: begin
                frame_o[TOP -: RN_W]                  = rn_i;
                frame_o[TOP-RN_W -: DIV_W]            = '0;
                frame_o[TOP-RN_W-DIV_W -: AUTH_W]     = auth_i;
                len_o                                 = CNT_W'(AUTH_LEN);
            end
            OP_WR: begin
                frame_o[TOP -: ADDR_W]                = addr_i;
                frame_o[TOP-ADDR_W]                   = ^addr_i;
                frame_o[TOP-ADDR_W-1 -: GW]           = grid;
                len_o                                 = CNT_W'(WR_LEN);
            end
            OP_PIN: begin
                frame_o[TOP -: ID_W]                  = tagid_i;
                frame_o[TOP-ID_W -: PIN_W]            = pin_i;
                len_o                                 = CNT_W'(PIN_LEN);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lftx_frame_ser.sv
module lftx_frame_ser
    import lftx_pkg::*;
#(
    parameter int RN_W   = 56,
    parameter int DIV_W  = 7,
    parameter int AUTH_W = 28,
    parameter int ADDR_W = 4,
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int ID_W   = 32,
    parameter int PIN_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2:0]           cmd_i,
    input  logic                 sync_i,
    input  logic                 tick_i,
    input  logic [RN_W-1:0]      rn_i,
    input  logic [AUTH_W-1:0]    auth_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ROWS*COLS-1:0] wword_i,
    input  logic [ID_W-1:0]      tagid_i,
    input  logic [PIN_W-1:0]     pin_i,
    output logic                 txd_o,
    output logic                 txv_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam int GW       = (ROWS + 1) * (COLS + 1);
    localparam int AUTH_LEN = PREFIX_W + RN_W + DIV_W + AUTH_W;
    localparam int WR_LEN   = PREFIX_W + ADDR_W + 1 + GW;
    localparam int PIN_LEN  = PREFIX_W + ID_W + PIN_W;
    localparam int MAX_AW   = (AUTH_LEN > WR_LEN) ? AUTH_LEN : WR_LEN;
    localparam int FRAME_W  = (MAX_AW > PIN_LEN) ? MAX_AW : PIN_LEN;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        st_e                st;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               txd;
        logic               txv;
        logic               done;
    } regs_t;

    regs_t              r_d, r_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               known;

    lftx_frame_build #(
        .RN_W(RN_W), .DIV_W(DIV_W), .AUTH_W(AUTH_W), .ADDR_W(ADDR_W),
        .ROWS(ROWS), .COLS(COLS), .ID_W(ID_W), .PIN_W(PIN_W),
        .FRAME_W(FRAME_W), .CNT_W(CNT_W)
    ) u_build (
        .cmd_i   (cmd_i),
        .rn_i    (rn_i),
        .auth_i  (auth_i),
        .addr_i  (addr_i),
        .wword_i (wword_i),
        .tagid_i (tagid_i),
        .pin_i   (pin_i),
        .frame_o (frame),
        .len_o   (len),
        .known_o (known)
    );

    always_comb begin
        r_d      = r_q;
        r_d.txv  = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i && known) begin
                    r_d.st  = S_ARMED;
                    r_d.sr  = frame;
                    r_d.cnt = len;
                end
            end
            S_ARMED: begin
                if (sync_i) begin
                    r_d.st = S_SEND;
                end
            end
            S_SEND: begin
                if (tick_i) begin
                    r_d.txd = r_q.sr[FRAME_W-1];
                    r_d.txv = 1'b1;
                    r_d.sr  = {r_q.sr[FRAME_W-2:0], 1'b0};
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd_o  = r_q.txd;
    assign txv_o  = r_q.txv;
    assign done_o = r_q.done;
    assign busy_o = (r_q.st != S_IDLE);

endmodule

// File: rtl/lftx_frame_ser_chk.sv
module lftx_frame_ser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] cmd_i,
    input logic       tick_i,
    input logic       txv_o,
    input logic       busy_o,
    input logic       done_o
);

    AST_TXV_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        txv_o |-> $past(tick_i)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !txv_o); // R2

    AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (txv_o && !busy_o)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R11

    AST_BAD_OP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (cmd_i == 3'b000 || cmd_i == 3'b110)) |=> !busy_o); // R12

endmodule

bind lftx_frame_ser lftx_frame_ser_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cmd_i   (cmd_i),
    .tick_i  (tick_i),
    .txv_o   (txv_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/tb_lftx_frame_ser.sv
module tb_lftx_frame_ser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = 3'b000;
    logic        sync = 1'b0;
    logic        tick = 1'b0;
    logic [55:0] rn = '0;
    logic [27:0] au = '0;
    logic [3:0]  addr = '0;
    logic [15:0] wword = '0;
    logic [31:0] tagid = '0;
    logic [31:0] pin = '0;
    logic        txd, txv, busy, done;

    int nchk = 0;
    int nbad = 0;

    bit eb [0:127];
    int elen;
    bit got [0:127];
    int ncap;

    always #2 clk = ~clk;

    lftx_frame_ser dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .sync_i(sync),
        .tick_i(tick), .rn_i(rn), .auth_i(au), .addr_i(addr), .wword_i(wword),
        .tagid_i(tagid), .pin_i(pin), .txd_o(txd), .txv_o(txv), .busy_o(busy),
        .done_o(done)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            eb[elen] = v[i];
            elen++;
        end
    endtask

    function automatic logic par(input logic [63:0] v);
        return logic'($countones(v) % 2);
    endfunction

    task automatic build_exp(input logic [2:0] c);
        elen = 0;
        push(64'(c), 5);
        push(64'(par(64'(c))), 1);
        case (c)
            3'b011: begin
                push(64'(rn), 56);
                push(64'd0, 7);
                push(64'(au), 28);
            end
            3'b101: begin
                push(64'(addr), 4);
                push(64'(par(64'(addr))), 1);
                for (int r = 0; r < 4; r++) begin
                    logic [3:0] nib;
                    nib = wword[15-4*r -: 4];
                    push(64'(nib), 4);
                    push(64'(par(64'(nib))), 1);
                end
                for (int c2 = 0; c2 < 4; c2++) begin
                    int ones;
                    ones = 0;
                    for (int r = 0; r < 4; r++) ones += int'(wword[15-4*r-c2]);
                    push(64'(ones % 2), 1);
                end
                push(64'(par(64'(wword))), 1);
            end
            3'b100: begin
                push(64'(tagid), 32);
                push(64'(pin), 32);
            end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b011:  return "R6";
            3'b101:  return "R7";
            3'b100:  return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic cmp_range(input int lo, input int hi, input string tag, input string what);
        int bad_at;
        bad_at = -1;
        for (int i = lo; i < hi; i++) begin
            if (bad_at < 0 && (i >= ncap || got[i] != eb[i])) bad_at = i;
        end
        if (bad_at < 0) chk(1'b1, tag, what, 0, 0);
        else chk(1'b0, tag, {what, " bit index ", $sformatf("%0d", bad_at)},
                 (bad_at < ncap) ? longint'(got[bad_at]) : -1, longint'(eb[bad_at]));
    endtask

    task automatic randomize_payload();
        rn    = {24'($urandom), $urandom};
        au    = 28'($urandom);
        addr  = 4'($urandom);
        wword = 16'($urandom);
        tagid = $urandom;
        pin   = $urandom;
    endtask

    task automatic run_frame(input logic [2:0] c, input int armed_ticks, input bit poke);
        int early, txv_bad, ndone, done_bad, limit;
        bit prev;
        cmd = c;
        build_exp(c);
        start = 1'b1;
        cyc();
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accepted start", longint'(busy), 1);
        early = 0;
        for (int k = 0; k < armed_ticks; k++) begin
            tick = 1'b1;
            if (poke && k == 0) begin
                randomize_payload();
                cmd = 3'b011;
                start = 1'b1;
            end
            cyc();
            start = 1'b0;
            if (txv) early++;
        end
        tick = 1'b0;
        chk(early == 0, "R2", "bits before sync", early, 0);
        chk(busy == 1'b1, "R11", "busy held while armed", longint'(busy), 1);
        sync = 1'b1;
        cyc();
        sync = 1'b0;
        ncap = 0; txv_bad = 0; ndone = 0; done_bad = 0; limit = 0;
        prev = 1'b0;
        while (limit < 1000) begin
            tick = ($urandom % 3) != 0;
            if (poke && ($urandom % 8) == 0) begin
                start = 1'b1;
                cmd = 3'b100;
                randomize_payload();
            end
            prev = tick;
            cyc();
            start = 1'b0;
            if (txv) begin
                if (ncap < 128) got[ncap] = txd;
                ncap++;
            end
            if (!(txv == 1'b0 || prev)) txv_bad++;
            if (done) begin
                ndone++;
                if (!txv || busy) done_bad++;
                break;
            end
            limit++;
        end
        tick = 1'b0;
        chk(txv_bad == 0, "R3", "bit strobe without tick", txv_bad, 0);
        chk(ncap == elen, tag_of(c), "frame length", ncap, elen);
        cmp_range(0, 6, "R4", "prefix");
        if (c == 3'b101) begin
            cmp_range(6, 11, "R7", "address field");
            cmp_range(11, elen, "R8", "parity grid");
        end else begin
            cmp_range(6, elen, tag_of(c), "payload");
        end
        chk(ndone == 1 && done_bad == 0, "R10", "done with final bit, busy low",
            done_bad, 0);
        cyc();
        chk(done == 1'b0 && txv == 1'b0, "R10", "done single pulse", longint'(done), 0);
        chk(busy == 1'b0, "R11", "idle after frame despite restarts", longint'(busy), 0);
    endtask

    task automatic bad_op(input logic [2:0] c);
        int leaked;
        cmd = c;
        start = 1'b1;
        cyc();
        start = 1'b0;
        chk(busy == 1'b0, "R12", $sformatf("opcode %0d rejected", c), longint'(busy), 0);
        sync = 1'b1;
        cyc();
        sync = 1'b0;
        leaked = 0;
        for (int k = 0; k < 5; k++) begin
            tick = 1'b1;
            cyc();
            if (txv) leaked++;
        end
        tick = 1'b0;
        chk(leaked == 0, "R12", "no bits after rejected opcode", leaked, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

    initial begin
        logic [2:0] ops [0:5];
        int seed;
        ops[0] = 3'b001; ops[1] = 3'b010; ops[2] = 3'b111;
        ops[3] = 3'b011; ops[4] = 3'b101; ops[5] = 3'b100;
        seed = $urandom(32'd4242);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk(busy == 0 && txv == 0 && done == 0 && txd == 0, "R1", "reset outputs",
            longint'({busy, txv, done, txd}), 0);

        bad_op(3'b000);
        bad_op(3'b110);

        // Directed corner cases
        for (int i = 0; i < 6; i++) begin
            randomize_payload();
            run_frame(ops[i], 2, 1'b0);
        end
        rn = '1; au = '1;
        run_frame(3'b011, 0, 1'b0);                       // R6 divider zeros between all-ones fields
        addr = 4'b1011; wword = 16'hFFFF;
        run_frame(3'b101, 1, 1'b0);                       // R8 all-ones grid
        addr = 4'b0000; wword = 16'h0001;
        run_frame(3'b101, 1, 1'b0);                       // R8 single set bit
        addr = 4'b0111; wword = 16'h8421;
        run_frame(3'b101, 3, 1'b1);                       // R11 restarts while busy
        tagid = 32'h8000_0001; pin = 32'hFFFF_FFFE;
        run_frame(3'b100, 0, 1'b1);                       // R9 / R11

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            randomize_payload();
            run_frame(ops[$urandom % 6], int'($urandom % 4), bit'($urandom % 2));
            if (($urandom % 4) == 0) bad_op((($urandom % 2) == 0) ? 3'b000 : 3'b110);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

endmodule